// File: doc/BRIEF.md
# Port Interrupt-On-Change Detector

This block watches a set of already-synchronized input pins spread over two ports and raises a change flag when any watched pin no longer matches a snapshot taken earlier. Each port holds its own snapshot register. A port's snapshot is refreshed only when the processor reads that port, and the processor signals that read with a one-cycle strobe. Every pin has its own enable bit. A pin whose bit is clear is left out of the comparison.

The flag behaves like a level condition that software can only acknowledge. While any enabled pin still differs from its snapshot, the flag is set again on every clock. A software clear therefore only takes effect after the mismatch has gone away. The mismatch ends when the port is read, or when the pin returns to its snapshot value. The flag goes to the interrupt controller through an overall group enable. That enable masks the request but never stops the flag from setting, so software can still poll it.

Top module: `ioc_change_monitor`

## Requirements
- R1: During synchronous reset (`rst_n` low) the flag is cleared and each snapshot is loaded from its port's live pins. After reset, pins that are unchanged leave `chg_flag` and `irq_req` at 0.
- R2: When an enabled port-A pin differs from its snapshot at a rising clock edge, `chg_flag` is 1 after that edge.
- R3: When an enabled port-B pin differs from its snapshot at a rising clock edge, `chg_flag` is 1 after that edge.
- R4: A pin whose enable bit is 0 cannot set the flag, and its snapshot keeps its old value. Setting the enable later while the pin still differs sets the flag on the next edge.
- R5: While a mismatch persists, a `flag_clr` pulse does not clear the flag. `chg_flag` is still 1 after the edge.
- R6: `pa_read` reloads only the port-A snapshot from `pa_pins`, and `pb_read` reloads only the port-B snapshot from `pb_pins`. A mismatch on the other port stays.
- R7: A read strobe and `flag_clr` in the same cycle leave `chg_flag` at 0 only if no enabled mismatch remains after the reload.
- R8: `irq_req` is 1 exactly when `chg_flag` is 1 and `grp_en` is 1. `grp_en` at 0 does not stop `chg_flag` from setting.
- R9: Only `flag_clr` clears the flag. When a read ends the mismatch without a clear, `chg_flag` stays 1.
- R10: When a changed pin returns to its snapshot value without a read, the mismatch ends, and a later `flag_clr` clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pa_pins | input | PA_W (3) | Synchronized port-A watched pins |
| pb_pins | input | PB_W (4) | Synchronized port-B watched pins |
| pa_en | input | PA_W (3) | Per-pin change enables, port A |
| pb_en | input | PB_W (4) | Per-pin change enables, port B |
| pa_read | input | 1 | Port-A read strobe, reloads port-A snapshot |
| pb_read | input | 1 | Port-B read strobe, reloads port-B snapshot |
| flag_clr | input | 1 | Software clear strobe for the flag |
| grp_en | input | 1 | Group enable for the interrupt request |
| chg_flag | output | 1 | Change flag |
| irq_req | output | 1 | Change request to the interrupt controller |

## Verification
The detector is driven with:
- single-pin changes on each port, which separate the two compare paths;
- a change on a disabled pin that is enabled later, which shows the snapshot was not silently refreshed;
- repeated clears during a standing mismatch, which separate the sticky re-set from a plain latch;
- a read of one port while both ports mismatch, which shows reloads are per port and that a read without a clear leaves the flag set;
- a pin that returns to its old value, which shows the compare is against the snapshot and not against the previous cycle;
- a change with the group enable low, which separates the flag from the request.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    typedef struct packed {
        logic flag;
    } flag_st_t;

    localparam flag_st_t FLAG_RESET = '{flag: 1'b0};

endpackage

// File: rtl/ioc_port_slice.sv
module ioc_port_slice #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] en,
    input  logic         rd,
    output logic         hit
);
    typedef struct packed {
        logic [W-1:0] snap;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic [W-1:0] diff_d;

    always_comb begin
        st_d = st_q;
        if (!rst_n || rd) begin
            st_d.snap = pins;
        end
        // compare against the snapshot as it will be after any reload
        diff_d = (pins ^ st_d.snap) & en;
        hit    = |diff_d;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end
endmodule

// File: rtl/ioc_flag_ctrl.sv
module ioc_flag_ctrl
    import ioc_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hits,
    input  logic             clr,
    output logic             flag
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flag = 1'b0;
        end
        if (|hits) begin
            st_d.flag = 1'b1;
        end
        if (!rst_n) begin
            st_d = FLAG_RESET;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/ioc_change_monitor.sv
module ioc_change_monitor #(
    parameter int PA_W = 3,
    parameter int PB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PA_W-1:0] pa_pins,
    input  logic [PB_W-1:0] pb_pins,
    input  logic [PA_W-1:0] pa_en,
    input  logic [PB_W-1:0] pb_en,
    input  logic            pa_read,
    input  logic            pb_read,
    input  logic            flag_clr,
    input  logic            grp_en,
    output logic            chg_flag,
    output logic            irq_req
);
    localparam int N_PORTS = 2;

    logic             hit_a;
    logic             hit_b;
    logic [N_PORTS-1:0] hits;

    ioc_port_slice #(.W(PA_W)) u_slice_a (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pa_pins),
        .en    (pa_en),
        .rd    (pa_read),
        .hit   (hit_a)
    );

    ioc_port_slice #(.W(PB_W)) u_slice_b (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pb_pins),
        .en    (pb_en),
        .rd    (pb_read),
        .hit   (hit_b)
    );

    assign hits = {hit_b, hit_a};

    ioc_flag_ctrl #(.N_SRC(N_PORTS)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hits  (hits),
        .clr   (flag_clr),
        .flag  (chg_flag)
    );

    assign irq_req = chg_flag & grp_en;
endmodule

// File: rtl/ioc_change_monitor_chk.sv
module ioc_change_monitor_chk #(
    parameter int PA_W = 3,
    parameter int PB_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PA_W-1:0] pa_en,
    input logic [PB_W-1:0] pb_en,
    input logic            flag_clr,
    input logic            grp_en,
    input logic            hit_a,
    input logic            hit_b,
    input logic            chg_flag,
    input logic            irq_req
);
    // R1: first cycle out of reset sees a clear flag
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !chg_flag);

    // R4: nothing enabled, nothing can set the flag
    p_no_set_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_en == '0 && pb_en == '0 && !chg_flag) |=> !chg_flag);

    // R5: a live mismatch from either slice forces the flag on
    p_persist_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a || hit_b) |=> chg_flag);

    // R8: request is masked by the group enable and follows the flag otherwise
    p_gate_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_en |-> !irq_req);
    p_gate_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_en && chg_flag) |-> irq_req);

    // R9: the flag drops only after a clear strobe
    p_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !flag_clr) |=> chg_flag);
endmodule

bind ioc_change_monitor ioc_change_monitor_chk #(.PA_W(PA_W), .PB_W(PB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pa_en    (pa_en),
    .pb_en    (pb_en),
    .flag_clr (flag_clr),
    .grp_en   (grp_en),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .chg_flag (chg_flag),
    .irq_req  (irq_req)
);

// File: tb/ioc_change_monitor_tb.sv
module ioc_change_monitor_tb;
    localparam int PA_W = 3;
    localparam int PB_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PA_W-1:0] pa_pins = 3'b101;
    logic [PB_W-1:0] pb_pins = 4'b0110;
    logic [PA_W-1:0] pa_en = '1;
    logic [PB_W-1:0] pb_en = '1;
    logic            pa_read = 1'b0;
    logic            pb_read = 1'b0;
    logic            flag_clr = 1'b0;
    logic            grp_en = 1'b1;
    logic            chg_flag;
    logic            irq_req;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ioc_change_monitor #(.PA_W(PA_W), .PB_W(PB_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pa_pins  (pa_pins),
        .pb_pins  (pb_pins),
        .pa_en    (pa_en),
        .pb_en    (pb_en),
        .pa_read  (pa_read),
        .pb_read  (pb_read),
        .flag_clr (flag_clr),
        .grp_en   (grp_en),
        .chg_flag (chg_flag),
        .irq_req  (irq_req)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // reload both snapshots and clear, leaving a quiet state
    task automatic settle();
        pa_read = 1'b1; pb_read = 1'b1; flag_clr = 1'b1;
        step();
        pa_read = 1'b0; pb_read = 1'b0; flag_clr = 1'b0;
        chk(chg_flag, 1'b0, "R7 read+clear with no mismatch left");
    endtask

    task automatic t_reset();
        repeat (3) step();
        rst_n = 1'b1;
        repeat (3) step();
        chk(chg_flag, 1'b0, "R1 flag after reset");
        chk(irq_req, 1'b0, "R1 request after reset");
    endtask

    task automatic t_port_a();
        pa_pins[1] = ~pa_pins[1];
        step();
        chk(chg_flag, 1'b1, "R2 port A change sets flag");
        chk(irq_req, 1'b1, "R8 request follows flag");
        settle();
    endtask

    task automatic t_port_b();
        pb_pins[3] = ~pb_pins[3];
        step();
        chk(chg_flag, 1'b1, "R3 port B change sets flag");
        settle();
    endtask

    task automatic t_disabled();
        pb_en[0] = 1'b0;
        pb_pins[0] = ~pb_pins[0];
        repeat (3) step();
        chk(chg_flag, 1'b0, "R4 disabled pin ignored");
        pb_en[0] = 1'b1;
        step();
        chk(chg_flag, 1'b1, "R4 snapshot kept, enable exposes change");
        settle();
    endtask

    task automatic t_persist();
        pa_pins[0] = ~pa_pins[0];
        step();
        for (int i = 0; i < 2; i++) begin
            flag_clr = 1'b1;
            step();
            flag_clr = 1'b0;
            chk(chg_flag, 1'b1, "R5 clear does not stick during mismatch");
        end
        settle();
    endtask

    task automatic t_partial_read();
        pa_pins[2] = ~pa_pins[2];
        pb_pins[1] = ~pb_pins[1];
        step();
        pa_read = 1'b1; flag_clr = 1'b1;
        step();
        pa_read = 1'b0; flag_clr = 1'b0;
        chk(chg_flag, 1'b1, "R7 read A+clear with B mismatch");
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(chg_flag, 1'b1, "R6 port A read leaves port B mismatch");
        pb_read = 1'b1;
        step();
        pb_read = 1'b0;
        step();
        chk(chg_flag, 1'b1, "R9 read alone keeps flag");
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(chg_flag, 1'b0, "R6 clear after both reads");
    endtask

    task automatic t_gate();
        grp_en = 1'b0;
        pb_pins[2] = ~pb_pins[2];
        step();
        chk(chg_flag, 1'b1, "R8 flag sets with group disabled");
        chk(irq_req, 1'b0, "R8 request masked");
        grp_en = 1'b1;
        #1;
        chk(irq_req, 1'b1, "R8 request after group enable");
        settle();
        chk(irq_req, 1'b0, "R8 request drops with flag");
    endtask

    task automatic t_return();
        pa_pins[1] = ~pa_pins[1];
        step();
        chk(chg_flag, 1'b1, "R10 change sets flag");
        pa_pins[1] = ~pa_pins[1];
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(chg_flag, 1'b0, "R10 returned pin lets clear stick");
    endtask

    initial begin
        t_reset();
        t_port_a();
        t_port_b();
        t_disabled();
        t_persist();
        t_partial_read();
        t_gate();
        t_return();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule